// File: doc/BRIEF.md
# Sixteen-pin GPIO bank with interrupt detection

This block is one bank of general-purpose pins controlled through a small word-addressed register port. Each pin is an input or an output. Its output value comes from one of four places: the normal output register, a sleep-mode value, a battery-fault value, or a shared external LED control line. Inputs pass through a synchroniser. Each pin can then raise a latched interrupt on a level or on an edge, and the polarity is chosen per pin.

Software sets the bank up by writing byte-addressed 16-bit registers. The low two address bits are ignored. Software reads the live pin levels back, and clears interrupt status by writing ones. The bank drives one interrupt request line. That line is the OR of every status bit that its mask leaves enabled. While the chip sleeps, a separate sleep mask replaces the normal mask.

Top module: `pin_bank`

## Requirements
- R1: After reset the mask, sleep-mask and trigger-type registers read 0xFFFF. Every other register reads 0x0000, pin_oe is 0 and irq is 0.
- R2: The word offsets are 0x00 mask, 0x04 direction, 0x08 output, 0x0C trigger type, 0x10 edge select, 0x14 level select, 0x18 sleep mask, 0x1C sleep output, 0x20 battery-fault output, 0x24 status, 0x28 alternate function, 0x2C sleep config and 0x30 pin levels. Every register except 0x24 and 0x30 reads back the value last written to it. Sleep config is plain storage. A write to 0x30 has no effect. Offsets 0x34 to 0x3C read 0.
- R3: pin_oe bit i equals direction bit i (1 = output). With no override active, pin_out bit i equals output register bit i (0 = low).
- R4: With trigger-type bit 0 (level), status bit i sets when the synchronised pin equals level-select bit i (1 = high). The status bit sets again on each cycle that the level persists.
- R5: With trigger-type bit 1 (edge), status bit i sets once for a change of the synchronised pin. A rising change counts when edge-select bit i is 1, and a falling change counts when it is 0. A change in the other direction sets nothing.
- R6: Writing 1 to a bit of 0x24 clears that status bit. The clear wins over a detection in the same cycle. Status bits that are set and not cleared hold their value.
- R7: irq is the OR of status bits whose mask bit is 0. While sleep_mode is 1, the sleep-mask register takes the place of the mask register.
- R8: Output priority is battery fault, then sleep mode, then alternate function. batt_fault selects the battery-fault register. Otherwise sleep_mode selects the sleep-output register. Otherwise an alternate-function bit of 1 routes led_ctl to that pin. Otherwise the pin drives the output register.
- R9: Offset 0x30 returns pin_in as it was two clock edges earlier, through a two-stage synchroniser. A status bit sets on the third edge after a pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Value driven on each pin |
| pin_oe | output | 16 | Output enable of each pin |
| sleep_mode | input | 1 | Chip is in sleep mode |
| batt_fault | input | 1 | Battery-fault condition |
| led_ctl | input | 1 | External LED control level |
| irq | output | 1 | Combined bank interrupt request |

## Verification
The assertions assume that the bus gives one write strobe per access and keeps bus_wr low during reset. They also assume that pin_in stays at zero through reset, so that no detection is pending when reset is released. The bench meets these conditions. It changes pins and bus signals only on falling clock edges, holds pin_in low until reset is released, and changes the trigger and level registers only while the pins sit at a known level. It then clears status before each new sweep, so every expected status value comes from one known pin change.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
   // word index = byte offset / 4
   localparam int REG_MASK  = 0;
   localparam int REG_DIR   = 1;
   localparam int REG_OUT   = 2;
   localparam int REG_TRIG  = 3;
   localparam int REG_EDGE  = 4;
   localparam int REG_LVL   = 5;
   localparam int REG_SMASK = 6;
   localparam int REG_SOUT  = 7;
   localparam int REG_BFOUT = 8;
   localparam int REG_STAT  = 9;
   localparam int REG_ALT   = 10;
   localparam int REG_SCFG  = 11;
   localparam int REG_PINS  = 12;
   localparam int NCFG      = 12;   // stored words, indexes 0..11
   localparam int NWORDS    = 13;   // including read-only pin word
endpackage

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
   import pin_bank_pkg::*;
#(
   parameter int NPIN   = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [NPIN-1:0]   bus_wdata,
   output logic [NPIN-1:0]   bus_rdata,
   input  logic [NPIN-1:0]   det,
   input  logic [NPIN-1:0]   pin_lvl,
   output logic [NPIN-1:0]   mask,
   output logic [NPIN-1:0]   dir,
   output logic [NPIN-1:0]   outv,
   output logic [NPIN-1:0]   trig,
   output logic [NPIN-1:0]   edge_rise,
   output logic [NPIN-1:0]   lvl_hi,
   output logic [NPIN-1:0]   smask,
   output logic [NPIN-1:0]   sout,
   output logic [NPIN-1:0]   bfout,
   output logic [NPIN-1:0]   status,
   output logic [NPIN-1:0]   alt,
   output logic [NPIN-1:0]   clr
);
   localparam int WIDX_W = ADDR_W - 2;

   logic [NPIN-1:0]   rf_q [NCFG];
   logic [WIDX_W-1:0] widx;

   assign widx = bus_addr[ADDR_W-1:2];
   assign clr  = (bus_wr && widx == WIDX_W'(REG_STAT)) ? bus_wdata : '0;

   function automatic logic [NPIN-1:0] rst_val(input int k);
      if (k == REG_MASK || k == REG_SMASK || k == REG_TRIG)
         return {NPIN{1'b1}};
      return {NPIN{1'b0}};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NCFG; k++) rf_q[k] <= rst_val(k);
      end else begin
         for (int k = 0; k < NCFG; k++) begin
            if (k == REG_STAT)
               rf_q[k] <= (rf_q[k] | det) & ~clr;   // clear wins
            else if (bus_wr && widx == WIDX_W'(k))
               rf_q[k] <= bus_wdata;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (widx == WIDX_W'(REG_PINS)) bus_rdata = pin_lvl;
      for (int k = 0; k < NCFG; k++)
         if (widx == WIDX_W'(k)) bus_rdata = rf_q[k];
   end

   assign mask      = rf_q[REG_MASK];
   assign dir       = rf_q[REG_DIR];
   assign outv      = rf_q[REG_OUT];
   assign trig      = rf_q[REG_TRIG];
   assign edge_rise = rf_q[REG_EDGE];
   assign lvl_hi    = rf_q[REG_LVL];
   assign smask     = rf_q[REG_SMASK];
   assign sout      = rf_q[REG_SOUT];
   assign bfout     = rf_q[REG_BFOUT];
   assign status    = rf_q[REG_STAT];
   assign alt       = rf_q[REG_ALT];
endmodule

// File: rtl/pin_bank_detect.sv
module pin_bank_detect #(
   parameter int NPIN        = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_in,
   input  logic [NPIN-1:0] trig,
   input  logic [NPIN-1:0] edge_rise,
   input  logic [NPIN-1:0] lvl_hi,
   output logic [NPIN-1:0] pin_lvl,
   output logic [NPIN-1:0] det
);
   logic [SYNC_STAGES-1:0][NPIN-1:0] stg_q;
   logic [NPIN-1:0]                  prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= '0;
      end else begin
         stg_q  <= {stg_q[SYNC_STAGES-2:0], pin_in};
         prev_q <= stg_q[SYNC_STAGES-1];
      end
   end

   assign pin_lvl = stg_q[SYNC_STAGES-1];

   logic [NPIN-1:0] rise, fall, lvl_hit;
   assign rise    = pin_lvl & ~prev_q;
   assign fall    = ~pin_lvl & prev_q;
   assign lvl_hit = ~(pin_lvl ^ lvl_hi);
   assign det     = (trig & ((edge_rise & rise) | (~edge_rise & fall)))
                  | (~trig & lvl_hit);
endmodule

// File: rtl/pin_bank_outmux.sv
module pin_bank_outmux #(
   parameter int NPIN = 16
) (
   input  logic            batt_fault,
   input  logic            sleep_mode,
   input  logic            led_ctl,
   input  logic [NPIN-1:0] dir,
   input  logic [NPIN-1:0] outv,
   input  logic [NPIN-1:0] sout,
   input  logic [NPIN-1:0] bfout,
   input  logic [NPIN-1:0] alt,
   output logic [NPIN-1:0] pin_out,
   output logic [NPIN-1:0] pin_oe
);
   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_comb begin
         if (batt_fault)      pin_out[i] = bfout[i];
         else if (sleep_mode) pin_out[i] = sout[i];
         else if (alt[i])     pin_out[i] = led_ctl;
         else                 pin_out[i] = outv[i];
      end
   end
   assign pin_oe = dir;
endmodule

// File: rtl/pin_bank.sv
module pin_bank #(
   parameter int NPIN        = 16,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [NPIN-1:0]   bus_wdata,
   output logic [NPIN-1:0]   bus_rdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   input  logic              sleep_mode,
   input  logic              batt_fault,
   input  logic              led_ctl,
   output logic              irq
);
   if (NPIN < 1 || NPIN > 32) begin : g_bad_npin
      $error("pin_bank: NPIN must be 1..32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("pin_bank: ADDR_W must be at least 6 to reach all words");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_bank: SYNC_STAGES must be at least 2");
   end

   logic [NPIN-1:0] mask_w, dir_w, outv_w, trig_w, edge_w, lvl_w;
   logic [NPIN-1:0] smask_w, sout_w, bfout_w, stat_w, alt_w, clr_w;
   logic [NPIN-1:0] det_w, pin_lvl_w, eff_mask;

   pin_bank_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .det       (det_w),
      .pin_lvl   (pin_lvl_w),
      .mask      (mask_w),
      .dir       (dir_w),
      .outv      (outv_w),
      .trig      (trig_w),
      .edge_rise (edge_w),
      .lvl_hi    (lvl_w),
      .smask     (smask_w),
      .sout      (sout_w),
      .bfout     (bfout_w),
      .status    (stat_w),
      .alt       (alt_w),
      .clr       (clr_w)
   );

   pin_bank_detect #(.NPIN(NPIN), .SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .trig      (trig_w),
      .edge_rise (edge_w),
      .lvl_hi    (lvl_w),
      .pin_lvl   (pin_lvl_w),
      .det       (det_w)
   );

   pin_bank_outmux #(.NPIN(NPIN)) u_out (
      .batt_fault (batt_fault),
      .sleep_mode (sleep_mode),
      .led_ctl    (led_ctl),
      .dir        (dir_w),
      .outv       (outv_w),
      .sout       (sout_w),
      .bfout      (bfout_w),
      .alt        (alt_w),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe)
   );

   assign eff_mask = sleep_mode ? smask_w : mask_w;
   assign irq      = |(stat_w & ~eff_mask);
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
   parameter int NPIN = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq,
   input logic [NPIN-1:0] status,
   input logic [NPIN-1:0] clr,
   input logic [NPIN-1:0] det,
   input logic            batt_fault,
   input logic [NPIN-1:0] pin_out,
   input logic [NPIN-1:0] pin_oe,
   input logic [NPIN-1:0] bfout
);
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr) |=> ((status & $past(clr)) == '0));                        // R6

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr))); // R6

   AST_DETECT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(det & ~clr) & ~status) == '0));                   // R4

   AST_NO_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !irq);                                          // R7

   AST_BATT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      batt_fault |-> ((pin_out & pin_oe) == (bfout & pin_oe)));          // R8
endmodule

bind pin_bank pin_bank_chk #(.NPIN(NPIN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .status     (stat_w),
   .clr        (clr_w),
   .det        (det_w),
   .batt_fault (batt_fault),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .bfout      (bfout_w)
);

// File: tb/pin_bank_tb.sv
module pin_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe;
   logic        sleep_mode = 1'b0, batt_fault = 1'b0, led_ctl = 1'b0;
   logic        irq;
   int          vec = 0;
   int          bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   pin_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .sleep_mode(sleep_mode),
      .batt_fault(batt_fault), .led_ctl(led_ctl), .irq(irq)
   );

   localparam logic [5:0] A_MASK = 6'h00, A_DIR = 6'h04, A_OUT = 6'h08,
      A_TRIG = 6'h0C, A_EDGE = 6'h10, A_LVL = 6'h14, A_SMASK = 6'h18,
      A_SOUT = 6'h1C, A_BF = 6'h20, A_STAT = 6'h24, A_ALT = 6'h28,
      A_SCFG = 6'h2C, A_PINS = 6'h30;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      vec++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [15:0] rst_exp(input int k);
      if (k == 0 || k == 3 || k == 6) return 16'hFFFF;
      return 16'h0000;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [15:0] bit_i;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);

      // R1 reset values
      for (int k = 0; k < 13; k++) begin
         rd(6'(k * 4), d);
         chk($sformatf("R1 reset word %0d", k), d, rst_exp(k));
      end
      chk("R1 irq after reset", irq, 0);
      chk("R1 oe after reset", pin_oe, 0);

      // R2 register map write/readback
      for (int k = 0; k < 12; k++)
         if (k != 9) wr(6'(k * 4), 16'h1234 ^ 16'(k * 16'h0F31));
      for (int k = 0; k < 12; k++)
         if (k != 9) begin
            rd(6'(k * 4), d);
            chk($sformatf("R2 readback word %0d", k), d, 16'h1234 ^ 16'(k * 16'h0F31));
         end
      wr(A_PINS, 16'hFFFF);
      rd(A_PINS, d);
      chk("R2 pin word write ignored", d, 16'h0000);
      for (int a = 13; a < 16; a++) begin
         rd(6'(a * 4), d);
         chk($sformatf("R2 unmapped word %0d", a), d, 16'h0000);
      end
      // restore quiet configuration
      wr(A_TRIG, 16'hFFFF); wr(A_LVL, 16'hFFFF); wr(A_MASK, 16'hFFFF);
      wr(A_SMASK, 16'hFFFF); wr(A_ALT, 16'h0000); wr(A_EDGE, 16'h0000);
      wr(A_STAT, 16'hFFFF);
      rd(A_STAT, d);
      chk("R6 status cleared", d, 16'h0000);

      // R3 direction and output
      for (int p = 0; p < 8; p++) begin
         wr(A_DIR, 16'(p * 16'h1111) ^ 16'hA5C3);
         wr(A_OUT, 16'(p * 16'h0707) ^ 16'h3C96);
         #1;
         chk("R3 oe follows direction", pin_oe, 16'(p * 16'h1111) ^ 16'hA5C3);
         chk("R3 out follows output reg", pin_out, 16'(p * 16'h0707) ^ 16'h3C96);
      end

      // R9 pin level readback latency
      pin_in = 16'hBEEF;
      cyc(1);
      rd(A_PINS, d);
      chk("R9 pins after one edge still old", d, 16'h0000);
      cyc(1);
      rd(A_PINS, d);
      chk("R9 pins after two edges", d, 16'hBEEF);
      pin_in = 16'h0000;
      cyc(3);
      wr(A_STAT, 16'hFFFF);

      // R4 level detection, high polarity, per pin
      wr(A_LVL, 16'hFFFF);
      wr(A_TRIG, 16'h0000);
      wr(A_STAT, 16'hFFFF);
      for (int i = 0; i < 16; i++) begin
         bit_i = 16'h1 << i;
         pin_in = bit_i;
         cyc(2);
         rd(A_STAT, d);
         chk($sformatf("R9 no status before third edge pin %0d", i), d, 16'h0000);
         cyc(1);
         rd(A_STAT, d);
         chk($sformatf("R4 high level pin %0d", i), d, bit_i);
         wr(A_STAT, bit_i);
         rd(A_STAT, d);
         chk($sformatf("R6 clear wins pin %0d", i), d, 16'h0000);
         cyc(1);
         rd(A_STAT, d);
         chk($sformatf("R4 level re-sets pin %0d", i), d, bit_i);
         pin_in = 16'h0000;
         cyc(3);
         wr(A_STAT, 16'hFFFF);
         rd(A_STAT, d);
         chk($sformatf("R6 cleared after drop pin %0d", i), d, 16'h0000);
      end
      // R4 low polarity: all pins low
      wr(A_LVL, 16'h0000);
      cyc(1);
      rd(A_STAT, d);
      chk("R4 low level all pins", d, 16'hFFFF);
      wr(A_TRIG, 16'hFFFF);
      wr(A_LVL, 16'hFFFF);
      wr(A_STAT, 16'hFFFF);
      rd(A_STAT, d);
      chk("R6 clear after low-level sweep", d, 16'h0000);

      // R5 edge detection, even pins rising, odd pins falling
      wr(A_EDGE, 16'h5555);
      for (int i = 0; i < 16; i++) begin
         bit_i = 16'h1 << i;
         pin_in = bit_i;
         cyc(3);
         rd(A_STAT, d);
         chk($sformatf("R5 rising pin %0d", i), d, (i % 2 == 0) ? bit_i : 16'h0);
         wr(A_STAT, 16'hFFFF);
         cyc(2);
         rd(A_STAT, d);
         chk($sformatf("R5 one-shot pin %0d", i), d, 16'h0000);
         pin_in = 16'h0000;
         cyc(3);
         rd(A_STAT, d);
         chk($sformatf("R5 falling pin %0d", i), d, (i % 2 == 1) ? bit_i : 16'h0);
         wr(A_STAT, 16'hFFFF);
      end

      // R7 interrupt masking, normal and sleep
      pin_in = 16'h0004;
      cyc(3);
      #1;
      chk("R7 irq masked", irq, 0);
      wr(A_MASK, 16'hFFFB);
      #1;
      chk("R7 irq unmasked", irq, 1);
      sleep_mode = 1'b1;
      #1;
      chk("R7 sleep mask replaces mask", irq, 0);
      wr(A_SMASK, 16'hFFFB);
      #1;
      chk("R7 sleep mask unmasked", irq, 1);
      sleep_mode = 1'b0;
      wr(A_MASK, 16'hFFFF);
      #1;
      chk("R7 irq masked again", irq, 0);
      wr(A_SMASK, 16'hFFFF);
      pin_in = 16'h0000;
      wr(A_STAT, 16'hFFFF);

      // R8 output priority sweep
      wr(A_DIR, 16'hFFFF); wr(A_OUT, 16'h00FF); wr(A_SOUT, 16'h0F0F);
      wr(A_BF, 16'h3333); wr(A_ALT, 16'h5555);
      for (int c = 0; c < 8; c++) begin
         logic [15:0] e;
         @(negedge clk);
         batt_fault = c[2]; sleep_mode = c[1]; led_ctl = c[0];
         #1;
         if (c[2]) e = 16'h3333;
         else if (c[1]) e = 16'h0F0F;
         else e = (16'h5555 & {16{c[0]}}) | (16'h00FF & ~16'h5555);
         chk($sformatf("R8 priority combo %0d", c), pin_out, e);
      end
      batt_fault = 1'b0; sleep_mode = 1'b0; led_ctl = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule